// File: doc/BRIEF.md
# Rename Stage Stall Controller

This block is the flow-control state machine of a register-rename pipeline stage. Each cycle decode offers up to `W` instructions. Each instruction carries three attribute bits: barrier, serialize-after and memory. The controller decides how many of them move on to the back end this cycle. Instructions it cannot send wait in an internal skid buffer. Decode is held off whenever that buffer cannot take a full group. The register mapping is not modelled here. A single flag says whether free physical registers exist.

Sending is limited by the free-entry counts of the reorder buffer, the issue queue and the load/store queue. Instructions sent in the previous cycle are not yet included in those counts, so they are subtracted first. Several other inputs also affect sending: hold requests from the execute and commit stages, the register-availability flag, and a squash request. Barrier instructions are sent only when the reorder buffer is empty and nothing is in flight toward it. The block reports four things every cycle: the number of instructions sent, a code for the queue that stopped sending, the hold signal to decode, and its current state.

States, with their codes on `state_o`:
- RUNNING = 0
- IDLE = 1
- START_SQUASH = 2
- SQUASHING = 3
- BLOCKED = 4
- UNBLOCKING = 5
- SERIALIZE_STALL = 6

Transitions:
- **Squash entry**: any non-squash state goes to START_SQUASH when `squash` is high.
- **Squash sequence**: START_SQUASH always goes to SQUASHING. SQUASHING stays while `squash` is held and then goes to IDLE.
- **Block**: a hold request, a lack of registers, or a full queue leads to BLOCKED.
- **Barrier wait**: a barrier that cannot yet go leads to SERIALIZE_STALL.
- **Release**: BLOCKED goes to UNBLOCKING on its first cycle with no stop.
- **Resume**: UNBLOCKING, and any stop-free cycle that leaves the skid buffer non-empty, goes to UNBLOCKING. With the buffer empty, the next state is RUNNING if something was sent and IDLE otherwise.

Top module: `rename_stall_ctrl`

## Requirements
- R1: After reset the state is IDLE (1), `decode_stall` is 0, `sent_count` is 0 and `stall_src` is 3.
- R2: Only the valid slots counted from slot 0 up to the first invalid slot are offered. Offered instructions are taken in order, skid buffer entries first, and at most `W` are sent per cycle. `sent_count` is the number sent this cycle.
- R3: Each queue's usable space is its free count minus what was sent in the previous cycle. For the load/store queue only memory instructions are counted. An instruction is sent only if the instructions already sent this cycle leave room for it in the reorder buffer and the issue queue, and also in the load/store queue when it is a memory instruction.
- R4: When a full queue stops sending, `stall_src` names it with fixed priority: reorder buffer = 0, then issue queue = 1, then load/store queue = 2. In every other cycle it is 3.
- R5: Unsent instructions stay in a skid buffer of depth 2·`W` and are sent first in later cycles. `decode_stall` is 1 when the free space is less than `W`, and decode input offered during such a cycle is ignored. In RUNNING the skid buffer is empty.
- R6: A hold request from execute or commit sends nothing, even with no input, and leads to BLOCKED. So does a clear register-availability flag when an instruction is offered. In both cases `stall_src` is 3.
- R7: BLOCKED never moves straight to RUNNING or IDLE; it passes through UNBLOCKING. UNBLOCKING is left only when the skid buffer is empty after the cycle.
- R8: A barrier instruction is sent only as the first instruction of its cycle, while `rob_empty` is 1 and nothing was sent in the previous cycle. Otherwise sending stops before it and the next state is SERIALIZE_STALL. No instruction follows a barrier in the same cycle.
- R9: A serialize-after instruction ends its cycle's group. The next instruction sent is treated as a barrier.
- R10: A squash sends nothing and empties the skid buffer, the offered input and the pending serialize-after flag. The state then runs START_SQUASH, SQUASHING (held while squash stays high), IDLE. `decode_stall` is 1 in the squash cycle and in both squash states.
- R11: A cycle with no stop and an empty skid buffer leads to RUNNING if anything was sent and to IDLE otherwise. A full queue stops sending even when the register flag is high, and the next state is BLOCKED.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | W | Valid bit per decode slot |
| in_barrier | input | W | Slot holds a barrier instruction |
| in_ser_after | input | W | Slot holds a serialize-after instruction |
| in_mem | input | W | Slot needs a load/store queue entry |
| rob_free | input | CNT_W | Free reorder buffer entries |
| iq_free | input | CNT_W | Free issue queue entries |
| lsq_free | input | CNT_W | Free load/store queue entries |
| rob_empty | input | 1 | Reorder buffer holds nothing |
| hold_exec | input | 1 | Hold request from execute |
| hold_commit | input | 1 | Hold request from commit |
| regs_avail | input | 1 | Free physical registers exist |
| squash | input | 1 | Squash request |
| decode_stall | output | 1 | Hold decode this cycle |
| sent_count | output | clog2(W+1) | Instructions sent this cycle |
| stall_src | output | 2 | Queue that stopped sending (0/1/2, 3 none) |
| state_o | output | 3 | Current state code |

## Verification
Directed groups are run first.
- A full group of plain instructions with ample room shows that all slots pass in one cycle.
- A group sent right after another, against a small reorder buffer count, separates the in-flight subtraction from the raw free count.
- Queues are starved one at a time to show the source priority.
- Barriers placed mid-group and at the head, and serialize-after at the head, distinguish the gating on `rob_empty` from the gating on the in-flight count.
- Repeated holds fill the skid buffer to show that decode is held and that input is ignored.
- A squash with a loaded buffer shows the flush.

A long seeded random run then mixes all inputs, including sparse squashes. Every cycle is compared against a bench-side model.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

    typedef enum logic [2:0] {
        ST_RUN       = 3'd0,
        ST_IDLE      = 3'd1,
        ST_SQ_START  = 3'd2,
        ST_SQ        = 3'd3,
        ST_BLOCKED   = 3'd4,
        ST_UNBLOCK   = 3'd5,
        ST_SER_STALL = 3'd6
    } rs_state_e;

    typedef enum logic [1:0] {
        SRC_ROB  = 2'd0,
        SRC_IQ   = 2'd1,
        SRC_LSQ  = 2'd2,
        SRC_NONE = 2'd3
    } src_e;

    typedef enum logic [2:0] {
        STOP_NONE  = 3'd0,
        STOP_EXT   = 3'd1,
        STOP_RES   = 3'd2,
        STOP_REGS  = 3'd3,
        STOP_BAR   = 3'd4,
        STOP_ORDER = 3'd5
    } stop_e;

    typedef struct packed {
        logic barrier;
        logic ser_after;
        logic mem;
    } slot_t;

endpackage

// File: rtl/rsc_skid.sv
module rsc_skid
    import rsc_pkg::*;
#(
    parameter int W = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  slot_t [W-1:0]                in_slots,
    input  logic [$clog2(W+1)-1:0]       in_cnt,
    input  logic [$clog2(W+1)-1:0]       take,
    output slot_t [W-1:0]                cand,
    output logic [$clog2(W+1)-1:0]       cand_cnt,
    output logic [$clog2(2*W+1)-1:0]     skid_cnt,
    output logic [$clog2(2*W+1)-1:0]     skid_next
);
    localparam int DEPTH = 2 * W;
    localparam int JOIN  = 3 * W;
    localparam int CW    = $clog2(W + 1);
    localparam int SKW   = $clog2(DEPTH + 1);
    localparam int TW    = $clog2(JOIN + 1);

    slot_t          store_q [DEPTH];
    slot_t          store_n [DEPTH];
    slot_t          joined  [JOIN];
    logic [SKW-1:0] cnt_q;
    logic [TW-1:0]  total;
    logic [TW-1:0]  remain;

    // Skid entries first, then the accepted decode slots behind them.
    always_comb begin
        for (int j = 0; j < JOIN; j++) joined[j] = '0;
        for (int j = 0; j < DEPTH; j++) begin
            if (j < int'(cnt_q)) joined[j] = store_q[j];
        end
        for (int i = 0; i < W; i++) begin
            if (i < int'(in_cnt)) joined[int'(cnt_q) + i] = in_slots[i];
        end
    end

    assign total  = TW'(cnt_q) + TW'(in_cnt);
    assign remain = total - TW'(take);

    generate
        for (genvar g = 0; g < W; g++) begin : g_cand
            assign cand[g] = joined[g];
        end
    endgenerate

    assign cand_cnt = (total >= TW'(W)) ? CW'(W) : CW'(total);

    always_comb begin
        for (int i = 0; i < DEPTH; i++) store_n[i] = joined[i + int'(take)];
    end

    assign skid_next = flush ? '0 : SKW'(remain);
    assign skid_cnt  = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) store_q[i] <= '0;
        end else begin
            cnt_q <= skid_next;
            for (int i = 0; i < DEPTH; i++) store_q[i] <= store_n[i];
        end
    end

    // R5
    skid_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |-> remain <= TW'(DEPTH));

    // R2
    take_within_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take <= cand_cnt);

endmodule

// File: rtl/rsc_select.sv
module rsc_select
    import rsc_pkg::*;
#(
    parameter int W     = 4,
    parameter int CNT_W = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  slot_t [W-1:0]           cand,
    input  logic [$clog2(W+1)-1:0]  cand_cnt,
    input  logic                    halt,
    input  logic                    ext_stall,
    input  logic                    regs_avail,
    input  logic [CNT_W-1:0]        rob_free,
    input  logic [CNT_W-1:0]        iq_free,
    input  logic [CNT_W-1:0]        lsq_free,
    input  logic                    rob_empty,
    input  logic [$clog2(W+1)-1:0]  inflight,
    input  logic [$clog2(W+1)-1:0]  inflight_mem,
    input  logic                    ser_pending,
    output logic [$clog2(W+1)-1:0]  take,
    output logic [$clog2(W+1)-1:0]  take_mem,
    output stop_e                   stop,
    output src_e                    src,
    output logic                    ser_set,
    output logic                    ser_clr
);
    localparam int CW = $clog2(W + 1);

    logic [CNT_W-1:0] rob_eff, iq_eff, lsq_eff;

    assign rob_eff = (rob_free > CNT_W'(inflight))     ? rob_free - CNT_W'(inflight)     : '0;
    assign iq_eff  = (iq_free  > CNT_W'(inflight))     ? iq_free  - CNT_W'(inflight)     : '0;
    assign lsq_eff = (lsq_free > CNT_W'(inflight_mem)) ? lsq_free - CNT_W'(inflight_mem) : '0;

    always_comb begin
        logic done;
        logic bar;
        take     = '0;
        take_mem = '0;
        stop     = STOP_NONE;
        src      = SRC_NONE;
        ser_set  = 1'b0;
        ser_clr  = 1'b0;
        done     = halt;
        if (!halt && ext_stall) begin
            stop = STOP_EXT;
            done = 1'b1;
        end
        for (int i = 0; i < W; i++) begin
            bar = cand[i].barrier || ((i == 0) && ser_pending);
            if (!done && (i < int'(cand_cnt))) begin
                if (!regs_avail) begin
                    stop = STOP_REGS;
                    done = 1'b1;
                end else if (rob_eff <= CNT_W'(take)) begin
                    stop = STOP_RES;
                    src  = SRC_ROB;
                    done = 1'b1;
                end else if (iq_eff <= CNT_W'(take)) begin
                    stop = STOP_RES;
                    src  = SRC_IQ;
                    done = 1'b1;
                end else if (cand[i].mem && (lsq_eff <= CNT_W'(take_mem))) begin
                    stop = STOP_RES;
                    src  = SRC_LSQ;
                    done = 1'b1;
                end else if (bar && ((i != 0) || !rob_empty || (inflight != '0))) begin
                    stop = STOP_BAR;
                    done = 1'b1;
                end else begin
                    take = take + CW'(1);
                    if (cand[i].mem) take_mem = take_mem + CW'(1);
                    if (bar) ser_clr = 1'b1;
                    if (cand[i].ser_after) ser_set = 1'b1;
                    if (bar || cand[i].ser_after) begin
                        stop = STOP_ORDER;
                        done = 1'b1;
                    end
                end
            end
        end
    end

    // R8
    barrier_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_clr |-> (rob_empty && inflight == '0 && take == CW'(1)));

    // R3
    rob_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        CNT_W'(take) <= rob_eff && CNT_W'(take) <= iq_eff);

endmodule

// File: rtl/rsc_fsm.sv
module rsc_fsm
    import rsc_pkg::*;
#(
    parameter int W = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        squash,
    input  stop_e                       stop,
    input  logic [$clog2(W+1)-1:0]      take,
    input  logic [$clog2(W+1)-1:0]      take_mem,
    input  logic                        ser_set,
    input  logic                        ser_clr,
    input  logic [$clog2(2*W+1)-1:0]    skid_next,
    output rs_state_e                   state,
    output logic                        halt,
    output logic [$clog2(W+1)-1:0]      inflight,
    output logic [$clog2(W+1)-1:0]      inflight_mem,
    output logic                        ser_pending
);
    rs_state_e state_q, state_n, flow_n;

    // Where a non-squash cycle leads.
    always_comb begin
        unique case (stop)
            STOP_EXT, STOP_RES, STOP_REGS: flow_n = ST_BLOCKED;
            STOP_BAR:                      flow_n = ST_SER_STALL;
            default: begin
                if (state_q == ST_BLOCKED)  flow_n = ST_UNBLOCK;
                else if (skid_next != '0)   flow_n = ST_UNBLOCK;
                else if (take != '0)        flow_n = ST_RUN;
                else                        flow_n = ST_IDLE;
            end
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_SQ_START: state_n = ST_SQ;
            ST_SQ:       state_n = squash ? ST_SQ : ST_IDLE;
            ST_RUN, ST_IDLE, ST_BLOCKED, ST_UNBLOCK, ST_SER_STALL:
                         state_n = squash ? ST_SQ_START : flow_n;
            default:     state_n = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            inflight     <= '0;
            inflight_mem <= '0;
            ser_pending  <= 1'b0;
        end else begin
            state_q      <= state_n;
            inflight     <= halt ? '0 : take;
            inflight_mem <= halt ? '0 : take_mem;
            ser_pending  <= squash  ? 1'b0 :
                            ser_set ? 1'b1 :
                            ser_clr ? 1'b0 : ser_pending;
        end
    end

    // Outputs.
    always_comb begin
        state = state_q;
        halt  = squash || (state_q == ST_SQ_START) || (state_q == ST_SQ);
    end

    // R10
    sq_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        squash |=> (state_q == ST_SQ_START || state_q == ST_SQ));

    // R10
    sq_sequence_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_SQ_START |=> state_q == ST_SQ);

    // R10
    halt_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> take == '0);

    // R7
    unblock_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_BLOCKED |=> (state_q != ST_RUN && state_q != ST_IDLE));

    // R6
    hold_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!squash && (stop == STOP_EXT || stop == STOP_REGS) && !halt) |=> state_q == ST_BLOCKED);

endmodule

// File: rtl/rename_stall_ctrl.sv
module rename_stall_ctrl
    import rsc_pkg::*;
#(
    parameter int W     = 4,
    parameter int CNT_W = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [W-1:0]            in_valid,
    input  logic [W-1:0]            in_barrier,
    input  logic [W-1:0]            in_ser_after,
    input  logic [W-1:0]            in_mem,
    input  logic [CNT_W-1:0]        rob_free,
    input  logic [CNT_W-1:0]        iq_free,
    input  logic [CNT_W-1:0]        lsq_free,
    input  logic                    rob_empty,
    input  logic                    hold_exec,
    input  logic                    hold_commit,
    input  logic                    regs_avail,
    input  logic                    squash,
    output logic                    decode_stall,
    output logic [$clog2(W+1)-1:0]  sent_count,
    output logic [1:0]              stall_src,
    output logic [2:0]              state_o
);
    localparam int DEPTH = 2 * W;
    localparam int CW    = $clog2(W + 1);
    localparam int SKW   = $clog2(DEPTH + 1);

    slot_t [W-1:0]  in_slots;
    slot_t [W-1:0]  cand;
    logic [CW-1:0]  lead_cnt, in_cnt, cand_cnt, take, take_mem;
    logic [CW-1:0]  inflight, inflight_mem;
    logic [SKW-1:0] skid_cnt, skid_next;
    logic           halt, ser_pending, ser_set, ser_clr;
    stop_e          stop;
    src_e           src;
    rs_state_e      state;

    generate
        for (genvar g = 0; g < W; g++) begin : g_slot
            assign in_slots[g] = '{barrier: in_barrier[g], ser_after: in_ser_after[g], mem: in_mem[g]};
        end
    endgenerate

    // Count valid slots from slot 0 up to the first gap.
    always_comb begin
        logic run;
        lead_cnt = '0;
        run      = 1'b1;
        for (int i = 0; i < W; i++) begin
            if (run && in_valid[i]) lead_cnt = lead_cnt + CW'(1);
            else                    run      = 1'b0;
        end
    end

    assign decode_stall = halt || (skid_cnt > SKW'(DEPTH - W));
    assign in_cnt       = decode_stall ? '0 : lead_cnt;

    rsc_skid #(.W(W)) u_skid (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (squash),
        .in_slots  (in_slots),
        .in_cnt    (in_cnt),
        .take      (take),
        .cand      (cand),
        .cand_cnt  (cand_cnt),
        .skid_cnt  (skid_cnt),
        .skid_next (skid_next)
    );

    rsc_select #(.W(W), .CNT_W(CNT_W)) u_sel (
        .clk          (clk),
        .rst_n        (rst_n),
        .cand         (cand),
        .cand_cnt     (cand_cnt),
        .halt         (halt),
        .ext_stall    (hold_exec || hold_commit),
        .regs_avail   (regs_avail),
        .rob_free     (rob_free),
        .iq_free      (iq_free),
        .lsq_free     (lsq_free),
        .rob_empty    (rob_empty),
        .inflight     (inflight),
        .inflight_mem (inflight_mem),
        .ser_pending  (ser_pending),
        .take         (take),
        .take_mem     (take_mem),
        .stop         (stop),
        .src          (src),
        .ser_set      (ser_set),
        .ser_clr      (ser_clr)
    );

    rsc_fsm #(.W(W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .squash       (squash),
        .stop         (stop),
        .take         (take),
        .take_mem     (take_mem),
        .ser_set      (ser_set),
        .ser_clr      (ser_clr),
        .skid_next    (skid_next),
        .state        (state),
        .halt         (halt),
        .inflight     (inflight),
        .inflight_mem (inflight_mem),
        .ser_pending  (ser_pending)
    );

    assign sent_count = take;
    assign stall_src  = src;
    assign state_o    = state;

    // R5
    run_skid_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == 3'd0 |-> skid_cnt == '0);

    // R5
    dstall_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (skid_cnt > SKW'(DEPTH - W)) |-> decode_stall);

    // R4
    src_sends_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_src != 2'd3 |-> sent_count < CW'(W));

endmodule

// File: tb/tb_rename_stall_ctrl.sv
module tb_rename_stall_ctrl;
    localparam int W       = 4;
    localparam int CNT_W   = 6;
    localparam int DEPTH   = 2 * W;
    localparam int CLK_PER = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [W-1:0]     in_valid = '0, in_barrier = '0, in_ser_after = '0, in_mem = '0;
    logic [CNT_W-1:0] rob_free = '0, iq_free = '0, lsq_free = '0;
    logic             rob_empty = 1'b0, hold_exec = 1'b0, hold_commit = 1'b0;
    logic             regs_avail = 1'b0, squash = 1'b0;
    logic             decode_stall;
    logic [2:0]       sent_count;
    logic [1:0]       stall_src;
    logic [2:0]       state_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // bench model of the controller
    int       m_state = 1;
    int       m_cnt = 0, m_infl = 0, m_infl_mem = 0;
    bit       m_ser = 0;
    bit [2:0] m_skid [DEPTH];

    rename_stall_ctrl #(.W(W), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_barrier(in_barrier),
        .in_ser_after(in_ser_after), .in_mem(in_mem), .rob_free(rob_free),
        .iq_free(iq_free), .lsq_free(lsq_free), .rob_empty(rob_empty),
        .hold_exec(hold_exec), .hold_commit(hold_commit), .regs_avail(regs_avail),
        .squash(squash), .decode_stall(decode_stall), .sent_count(sent_count),
        .stall_src(stall_src), .state_o(state_o)
    );

    always #(CLK_PER / 2) clk = ~clk;

    task automatic chk(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic drive(int vcnt, logic [W-1:0] bar, logic [W-1:0] sa, logic [W-1:0] mem,
                         int rob, int iq, int lsq, bit rempty, bit hold, bit regs, bit sq);
        for (int i = 0; i < W; i++) in_valid[i] = (i < vcnt);
        in_barrier   = bar;
        in_ser_after = sa;
        in_mem       = mem;
        rob_free     = CNT_W'(rob);
        iq_free      = CNT_W'(iq);
        lsq_free     = CNT_W'(lsq);
        rob_empty    = rempty;
        hold_exec    = hold;
        hold_commit  = 1'b0;
        regs_avail   = regs;
        squash       = sq;
    endtask

    // Evaluates the model for the driven inputs, checks the ports, advances the model.
    task automatic step(string tag);
        bit       halt, e_dst, done, bar;
        int       lead, acc, tot, cc, take, tmem, stop, src, robe, iqe, lsqe, nxt, flow;
        bit       sset, sclr;
        bit [2:0] jn [3*W];
        #1;
        halt  = squash || m_state == 2 || m_state == 3;
        e_dst = halt || (m_cnt > DEPTH - W);
        lead = 0;
        for (int i = 0; i < W; i++) begin
            if (in_valid[i] && lead == i) lead++;
        end
        acc = e_dst ? 0 : lead;
        for (int j = 0; j < 3 * W; j++) jn[j] = '0;
        for (int j = 0; j < m_cnt; j++) jn[j] = m_skid[j];
        for (int i = 0; i < acc; i++) jn[m_cnt + i] = {in_barrier[i], in_ser_after[i], in_mem[i]};
        tot  = m_cnt + acc;
        cc   = (tot > W) ? W : tot;
        robe = (int'(rob_free) > m_infl) ? int'(rob_free) - m_infl : 0;
        iqe  = (int'(iq_free) > m_infl) ? int'(iq_free) - m_infl : 0;
        lsqe = (int'(lsq_free) > m_infl_mem) ? int'(lsq_free) - m_infl_mem : 0;
        take = 0; tmem = 0; stop = 0; src = 3; sset = 0; sclr = 0; done = halt;
        if (!halt && (hold_exec || hold_commit)) begin stop = 1; done = 1; end
        for (int i = 0; i < W; i++) begin
            bar = jn[i][2] || (i == 0 && m_ser);
            if (!done && i < cc) begin
                if (!regs_avail) begin stop = 3; done = 1; end
                else if (robe <= take) begin stop = 2; src = 0; done = 1; end
                else if (iqe <= take) begin stop = 2; src = 1; done = 1; end
                else if (jn[i][0] && lsqe <= tmem) begin stop = 2; src = 2; done = 1; end
                else if (bar && (i != 0 || !rob_empty || m_infl != 0)) begin stop = 4; done = 1; end
                else begin
                    take++;
                    if (jn[i][0]) tmem++;
                    if (bar) sclr = 1;
                    if (jn[i][1]) sset = 1;
                    if (bar || jn[i][1]) begin stop = 5; done = 1; end
                end
            end
        end
        chk(tag, "sent_count", int'(sent_count), take);
        chk(tag, "stall_src", int'(stall_src), src);
        chk(tag, "decode_stall", int'(decode_stall), int'(e_dst));
        chk(tag, "state", int'(state_o), m_state);
        if (stop == 1 || stop == 2 || stop == 3) flow = 4;
        else if (stop == 4) flow = 6;
        else if (m_state == 4) flow = 5;
        else if (!squash && tot - take > 0) flow = 5;
        else if (take > 0) flow = 0;
        else flow = 1;
        if (m_state == 2) nxt = 3;
        else if (m_state == 3) nxt = squash ? 3 : 1;
        else nxt = squash ? 2 : flow;
        for (int i = 0; i < DEPTH; i++) m_skid[i] = jn[i + take];
        m_cnt      = squash ? 0 : tot - take;
        m_infl     = halt ? 0 : take;
        m_infl_mem = halt ? 0 : tmem;
        m_ser      = squash ? 0 : sset ? 1 : sclr ? 0 : m_ser;
        m_state    = nxt;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h0000_5EED));
        for (int i = 0; i < DEPTH; i++) m_skid[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        drive(0, 0, 0, 0, 20, 20, 20, 1, 0, 1, 0);
        #1;
        chk("R1", "state", int'(state_o), 1);
        chk("R1", "decode_stall", int'(decode_stall), 0);
        chk("R1", "sent_count", int'(sent_count), 0);
        chk("R1", "stall_src", int'(stall_src), 3);
        step("R1");

        // R2 full group, ample room
        drive(4, 0, 0, 0, 20, 20, 20, 1, 0, 1, 0);
        #1 chk("R2", "full group sent", int'(sent_count), 4);
        step("R2");
        // R11 nothing offered after running
        drive(0, 0, 0, 0, 20, 20, 20, 1, 0, 1, 0);
        #1 chk("R11", "state after send", int'(state_o), 0);
        step("R11");
        // R3 in-flight subtraction: send 4, then rob 6 leaves room for 2
        drive(4, 0, 0, 0, 20, 20, 20, 1, 0, 1, 0);
        step("R3");
        drive(4, 0, 0, 0, 6, 20, 20, 1, 0, 1, 0);
        #1 chk("R3", "sent with inflight", int'(sent_count), 2);
        step("R3");
        // R7 drain from BLOCKED
        drive(0, 0, 0, 0, 20, 20, 20, 1, 0, 1, 0);
        #1 chk("R7", "blocked state", int'(state_o), 4);
        step("R7");
        drive(0, 0, 0, 0, 20, 20, 20, 1, 0, 1, 0);
        #1 chk("R7", "unblocking state", int'(state_o), 5);
        step("R7");
        step("R7");
        // R4 source priority, one memory instruction
        drive(1, 0, 0, 4'b0001, 0, 0, 0, 1, 0, 1, 0);
        #1 chk("R4", "rob first", int'(stall_src), 0);
        step("R4");
        drive(0, 0, 0, 0, 5, 0, 0, 1, 0, 1, 0);
        #1 chk("R4", "iq second", int'(stall_src), 1);
        step("R4");
        drive(0, 0, 0, 0, 5, 5, 0, 1, 0, 1, 0);
        #1 chk("R4", "lsq third", int'(stall_src), 2);
        step("R4");
        drive(0, 0, 0, 0, 5, 5, 5, 1, 0, 1, 0);
        step("R4");
        step("R11");
        // R6 hold and missing registers
        drive(2, 0, 0, 0, 20, 20, 20, 1, 1, 1, 0);
        #1 chk("R6", "hold sends none", int'(sent_count), 0);
        step("R6");
        drive(0, 0, 0, 0, 20, 20, 20, 1, 0, 0, 0);
        #1 chk("R6", "no regs sends none", int'(sent_count), 0);
        step("R6");
        drive(0, 0, 0, 0, 20, 20, 20, 1, 0, 1, 0);
        step("R6");
        step("R6");
        step("R6");
        // R11 full queue with regs present leads to BLOCKED
        drive(2, 0, 0, 0, 0, 20, 20, 1, 0, 1, 0);
        step("R11");
        drive(0, 0, 0, 0, 20, 20, 20, 1, 0, 1, 0);
        #1 chk("R11", "blocked on full rob", int'(state_o), 4);
        step("R11");
        step("R11");
        step("R11");
        // R8 barrier in slot 2
        drive(4, 4'b0100, 0, 0, 20, 20, 20, 1, 0, 1, 0);
        #1 chk("R8", "stop before barrier", int'(sent_count), 2);
        step("R8");
        drive(0, 0, 0, 0, 20, 20, 20, 1, 0, 1, 0);
        #1 chk("R8", "serialize stall", int'(state_o), 6);
        chk("R8", "wait for inflight", int'(sent_count), 0);
        step("R8");
        #1 chk("R8", "barrier alone", int'(sent_count), 1);
        step("R8");
        drive(0, 0, 0, 0, 20, 20, 20, 0, 0, 1, 0);
        step("R8");
        step("R8");
        // R9 serialize-after at the head, then barrier-like follower
        drive(3, 0, 4'b0001, 0, 20, 20, 20, 1, 0, 1, 0);
        #1 chk("R9", "group ends", int'(sent_count), 1);
        step("R9");
        drive(0, 0, 0, 0, 20, 20, 20, 1, 0, 1, 0);
        #1 chk("R9", "follower waits", int'(sent_count), 0);
        step("R9");
        #1 chk("R9", "follower alone", int'(sent_count), 1);
        step("R9");
        step("R9");
        step("R9");
        // R5 fill skid with holds; third group ignored
        drive(4, 0, 0, 0, 20, 20, 20, 1, 1, 1, 0);
        step("R5");
        step("R5");
        #1 chk("R5", "decode held", int'(decode_stall), 1);
        step("R5");
        drive(0, 0, 0, 0, 20, 20, 20, 1, 0, 1, 0);
        step("R5");
        step("R5");
        #1 chk("R5", "ignored group absent", int'(sent_count), 0);
        step("R5");
        // R10 squash with loaded skid
        drive(4, 0, 0, 0, 20, 20, 20, 1, 1, 1, 0);
        step("R10");
        drive(4, 0, 0, 0, 20, 20, 20, 1, 0, 1, 1);
        #1 chk("R10", "squash sends none", int'(sent_count), 0);
        step("R10");
        drive(4, 0, 0, 0, 20, 20, 20, 1, 0, 1, 0);
        #1 chk("R10", "start squash", int'(state_o), 2);
        chk("R10", "decode held", int'(decode_stall), 1);
        step("R10");
        #1 chk("R10", "squashing", int'(state_o), 3);
        step("R10");
        drive(0, 0, 0, 0, 20, 20, 20, 1, 0, 1, 0);
        #1 chk("R10", "idle after squash", int'(state_o), 1);
        chk("R10", "skid emptied", int'(sent_count), 0);
        step("R10");

        // seeded random mix
        for (int c = 0; c < 4000; c++) begin
            int v;
            v = int'($urandom_range(0, W));
            drive(v,
                  W'($urandom() & $urandom() & $urandom()),
                  W'($urandom() & $urandom() & $urandom()),
                  W'($urandom()),
                  int'($urandom_range(0, 9)), int'($urandom_range(0, 9)), int'($urandom_range(0, 6)),
                  ($urandom_range(0, 2) == 0), ($urandom_range(0, 7) == 0),
                  ($urandom_range(0, 7) != 0), ($urandom_range(0, 40) == 0));
            step("R2");
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule